// File: doc/BRIEF.md
# Multi-Channel Gamma Table Loader

This block holds the gamma correction tables for three display channels and applies them to a pixel stream. Each channel has one table per colour component, red, green and blue. Each table has 256 entries of 8 bits. The host loads the tables through a small register port. It first sets a linear table address, and can set an auto-increment flag at the same time. Each write to the data register then stores one entry. When the flag is set, that write also steps the address to the next entry, so a whole channel, or all three, can be streamed in one pass.

The linear address space is ordered by channel, then by colour, then by entry index. A channel's tables start at the channel number times 768. Within a channel, red occupies offsets 0..255, green 256..511 and blue 512..767. Internally the tables are split into one memory per colour component, so the pixel path can read all three components of a pixel in the same cycle.

The pixel path takes a channel number and three 8-bit components. It returns the corrected pixel one clock later if gamma is enabled for that channel, and the unchanged pixel otherwise. The host should reload the tables after re-enabling gamma if every channel had been disabled, because the table storage may then have been powered down.

Top module: `gamma_lut_loader`

## Requirements
- R1: After synchronous reset, the address register reads 0 with the auto-increment flag clear, all channel enables read 0, and out_valid is low.
- R2: A host write with select 0 loads the address register. Bit 15 is the auto-increment flag and bits 14..0 are the address; an address of 2304 or more loads 0. A read with select 0 returns the flag in bit 15 and the address in bits 11..0, one cycle after the read strobe.
- R3: A host write with select 1 stores host_wdata[7:0] at the current linear address. Linear address ch*768 + col*256 + idx selects entry idx of channel ch, where colour col is 0 for red, 1 for green and 2 for blue.
- R4: A data write with the auto-increment flag clear leaves the address unchanged. Successive writes therefore overwrite the same entry, and the last one wins.
- R5: A data write with the flag set advances the address by one. A data write at address 2303 stores its entry there and moves the address to 0.
- R6: A host write with select 2 loads the channel enables from host_wdata[2:0], with bit n for channel n. A read with select 2 returns them in bits 2..0. A read with select 1 or 3 returns 0, and a write with select 3 has no effect.
- R7: A pixel presented with pix_valid on a channel whose enable is set comes out one cycle later with each component replaced by that channel's table entry, indexed by the component value. out_valid is pix_valid delayed by one cycle.
- R8: A pixel on a channel whose enable is clear, or with channel code 3, comes out one cycle later with its components unchanged.
- R9: A data write and a lookup of the same entry in the same cycle both proceed. The lookup returns the entry's previous value, and later lookups return the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_sel | input | 2 | Write target: 0 address, 1 data, 2 enables, 3 none |
| host_wdata | input | 16 | Host write data |
| host_rd | input | 1 | Host read strobe |
| host_rsel | input | 2 | Read target: 0 address, 2 enables, others read 0 |
| host_rdata | output | 16 | Registered read data |
| pix_valid | input | 1 | Input pixel valid |
| pix_ch | input | 2 | Channel of the input pixel |
| pix_r | input | 8 | Red component in |
| pix_g | input | 8 | Green component in |
| pix_b | input | 8 | Blue component in |
| out_valid | output | 1 | Output pixel valid |
| out_r | output | 8 | Red component out |
| out_g | output | 8 | Green component out |
| out_b | output | 8 | Blue component out |

## Verification
Two situations are hard to reach from the ports.

The first is the wrap from the last table entry back to zero. Reaching it by streaming alone takes a full 2304-write sweep. The stimulus does that sweep once to load every table, then reaches the wrap a second time by loading address 2303 directly. It then confirms through lookups that both the entry before the wrap and the entry after it were written.

The second is a host write and a lookup that hit the same entry in the same cycle. The stimulus drives both strobes on one clock edge. The scoreboard expects the old value for that lookup and the new value for the lookup that follows.

// File: rtl/gamma_pkg.sv
package gamma_pkg;
  // Host register targets
  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_DATA = 2'd1,
    SEL_EN   = 2'd2,
    SEL_NONE = 2'd3
  } gl_sel_e;

  // Colour components per channel, in linear address order
  localparam int GL_COLOURS = 3;
endpackage

// File: rtl/gamma_lut_ram.sv
// Simple dual-port table memory: one write port, one registered read port.
// Read-before-write on a same-address collision.
module gamma_lut_ram #(
  parameter int DEPTH = 768,
  parameter int DW    = 8,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/gamma_addr_ctl.sv
// Host address register with auto-increment, and decode of the linear
// address into a colour memory select and a per-colour memory address.
module gamma_addr_ctl
  import gamma_pkg::*;
#(
  parameter int NCH = 3,
  parameter int DW  = 8,
  parameter int HW  = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [1:0]            wr_sel,
  input  logic [HW-1:0]         wr_data,
  output logic [$clog2(NCH*GL_COLOURS*(1<<DW))-1:0] addr_q,
  output logic                  autoinc_q,
  output logic [GL_COLOURS-1:0] col_we,
  output logic [$clog2(NCH*(1<<DW))-1:0] ram_waddr,
  output logic [DW-1:0]         ram_wdata
);
  localparam int ENT   = 1 << DW;
  localparam int TOTAL = NCH * GL_COLOURS * ENT;
  localparam int AW    = $clog2(TOTAL);
  localparam int RAW   = $clog2(NCH * ENT);
  localparam logic [AW-1:0] LAST_A = AW'(TOTAL - 1);

  logic data_wr, addr_wr;
  logic [GL_COLOURS-1:0] col_hit;

  assign data_wr   = wr_en && (wr_sel == SEL_DATA);
  assign addr_wr   = wr_en && (wr_sel == SEL_ADDR);
  assign ram_wdata = wr_data[DW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q    <= '0;
      autoinc_q <= 1'b0;
    end else if (addr_wr) begin
      autoinc_q <= wr_data[HW-1];
      addr_q    <= (int'(wr_data[HW-2:0]) < TOTAL) ? AW'(wr_data[HW-2:0]) : '0;
    end else if (data_wr && autoinc_q) begin
      addr_q <= (addr_q == LAST_A) ? '0 : addr_q + 1'b1;
    end
  end

  // Linear address -> (channel, colour, index)
  always_comb begin
    col_hit   = '0;
    ram_waddr = '0;
    for (int ch = 0; ch < NCH; ch++) begin
      for (int c = 0; c < GL_COLOURS; c++) begin
        if (int'(addr_q) >= (ch*GL_COLOURS + c)*ENT &&
            int'(addr_q) <  (ch*GL_COLOURS + c + 1)*ENT) begin
          col_hit[c] = 1'b1;
          ram_waddr  = RAW'(ch*ENT + int'(addr_q) - (ch*GL_COLOURS + c)*ENT);
        end
      end
    end
  end

  assign col_we = data_wr ? col_hit : '0;

  AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    int'(addr_q) < TOTAL); // R2
  AST_ONE_COLOUR_WE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(col_we)); // R3
  AST_NO_STEP: assert property (@(posedge clk) disable iff (rst)
    (data_wr && !autoinc_q) |=> $stable(addr_q)); // R4
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    (data_wr && autoinc_q && addr_q != LAST_A) |=> addr_q == $past(addr_q) + 1'b1); // R5
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (data_wr && autoinc_q && addr_q == LAST_A) |=> addr_q == '0); // R5
endmodule

// File: rtl/gamma_lut_loader.sv
module gamma_lut_loader
  import gamma_pkg::*;
#(
  parameter int NCH = 3,
  parameter int DW  = 8,
  parameter int HW  = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   host_wr,
  input  logic [1:0]             host_sel,
  input  logic [HW-1:0]          host_wdata,
  input  logic                   host_rd,
  input  logic [1:0]             host_rsel,
  output logic [HW-1:0]          host_rdata,
  input  logic                   pix_valid,
  input  logic [$clog2(NCH)-1:0] pix_ch,
  input  logic [DW-1:0]          pix_r,
  input  logic [DW-1:0]          pix_g,
  input  logic [DW-1:0]          pix_b,
  output logic                   out_valid,
  output logic [DW-1:0]          out_r,
  output logic [DW-1:0]          out_g,
  output logic [DW-1:0]          out_b
);
  localparam int ENT   = 1 << DW;
  localparam int DEPTH = NCH * ENT;
  localparam int RAW   = $clog2(DEPTH);
  localparam int AW    = $clog2(NCH * GL_COLOURS * ENT);

  logic [AW-1:0]         addr_q;
  logic                  autoinc_q;
  logic [GL_COLOURS-1:0] col_we;
  logic [RAW-1:0]        ram_waddr;
  logic [DW-1:0]         ram_wdata;
  logic [NCH-1:0]        en_q;
  logic [HW-1:0]         rd_mux;

  gamma_addr_ctl #(.NCH(NCH), .DW(DW), .HW(HW)) u_addr (
    .clk(clk), .rst(rst),
    .wr_en(host_wr), .wr_sel(host_sel), .wr_data(host_wdata),
    .addr_q(addr_q), .autoinc_q(autoinc_q),
    .col_we(col_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata)
  );

  // Channel enable register
  always_ff @(posedge clk) begin
    if (rst) en_q <= '0;
    else if (host_wr && host_sel == SEL_EN) en_q <= host_wdata[NCH-1:0];
  end

  // Host read path
  always_comb begin
    rd_mux = '0;
    case (host_rsel)
      SEL_ADDR: begin
        rd_mux[HW-1]   = autoinc_q;
        rd_mux[AW-1:0] = addr_q;
      end
      SEL_EN:  rd_mux[NCH-1:0] = en_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) host_rdata <= '0;
    else if (host_rd) host_rdata <= rd_mux;
  end

  // Pixel path
  logic                  ch_ok, lookup_on;
  logic [DW-1:0]         comp_in  [GL_COLOURS];
  logic [DW-1:0]         comp_lut [GL_COLOURS];
  logic [DW-1:0]         comp_byp [GL_COLOURS];
  logic [DW-1:0]         comp_out [GL_COLOURS];
  logic                  v_q, use_lut_q;

  assign comp_in[0] = pix_r;
  assign comp_in[1] = pix_g;
  assign comp_in[2] = pix_b;
  assign ch_ok      = int'(pix_ch) < NCH;

  always_comb begin
    lookup_on = 1'b0;
    for (int ch = 0; ch < NCH; ch++)
      if (int'(pix_ch) == ch) lookup_on = en_q[ch];
  end

  for (genvar c = 0; c < GL_COLOURS; c++) begin : g_col
    logic [RAW-1:0] raddr;
    assign raddr = ch_ok ? RAW'(int'(pix_ch)*ENT + int'(comp_in[c])) : '0;

    gamma_lut_ram #(.DEPTH(DEPTH), .DW(DW), .AW(RAW)) u_ram (
      .clk(clk), .we(col_we[c]), .waddr(ram_waddr), .wdata(ram_wdata),
      .raddr(raddr), .rdata(comp_lut[c])
    );

    always_ff @(posedge clk) begin
      if (rst) comp_byp[c] <= '0;
      else     comp_byp[c] <= comp_in[c];
    end

    assign comp_out[c] = use_lut_q ? comp_lut[c] : comp_byp[c];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q       <= 1'b0;
      use_lut_q <= 1'b0;
    end else begin
      v_q       <= pix_valid;
      use_lut_q <= pix_valid && lookup_on;
    end
  end

  assign out_valid = v_q;
  assign out_r     = comp_out[0];
  assign out_g     = comp_out[1];
  assign out_b     = comp_out[2];

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    pix_valid |=> out_valid); // R7
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (rst)
    !pix_valid |=> !out_valid); // R7
  AST_BYPASS_KEEP: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && !lookup_on) |=>
      (out_r == $past(pix_r) && out_g == $past(pix_g) && out_b == $past(pix_b))); // R8
endmodule

// File: tb/gamma_lut_loader_tb.sv
`timescale 1ns/1ps
module gamma_lut_loader_tb;
  localparam int TOTAL = 2304;

  logic        clk = 1'b0;
  logic        rst;
  logic        host_wr, host_rd, pix_valid;
  logic [1:0]  host_sel, host_rsel, pix_ch;
  logic [15:0] host_wdata, host_rdata;
  logic [7:0]  pix_r, pix_g, pix_b, out_r, out_g, out_b;
  logic        out_valid;

  always #4 clk = ~clk;

  gamma_lut_loader u_dut (
    .clk(clk), .rst(rst),
    .host_wr(host_wr), .host_sel(host_sel), .host_wdata(host_wdata),
    .host_rd(host_rd), .host_rsel(host_rsel), .host_rdata(host_rdata),
    .pix_valid(pix_valid), .pix_ch(pix_ch),
    .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
    .out_valid(out_valid), .out_r(out_r), .out_g(out_g), .out_b(out_b)
  );

  // Reference state built from the requirements
  logic [7:0] model [TOTAL];
  int         b_addr;
  bit         b_inc;
  logic [2:0] b_en;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  finished = 0;

  logic [23:0] exp_q [$];
  string       tag_q [$];

  function automatic logic [7:0] pat(int a);
    return 8'(a*7 + (a/256)*13 + 5);
  endfunction

  function automatic logic [23:0] expect_pix(int ch, logic [7:0] r, g, b);
    if (ch < 3 && b_en[ch])
      return {model[ch*768 + int'(r)], model[ch*768 + 256 + int'(g)],
              model[ch*768 + 512 + int'(b)]};
    return {r, g, b};
  endfunction

  task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic mirror(input logic [1:0] sel, input logic [15:0] d);
    case (sel)
      2'd0: begin b_inc = d[15]; b_addr = (int'(d[14:0]) < TOTAL) ? int'(d[14:0]) : 0; end
      2'd1: begin
        model[b_addr] = d[7:0];
        if (b_inc) b_addr = (b_addr == TOTAL-1) ? 0 : b_addr + 1;
      end
      2'd2: b_en = d[2:0];
      default: ;
    endcase
  endtask

  task automatic host_write(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_sel = sel; host_wdata = d;
    mirror(sel, d);
    @(posedge clk); #1;
    host_wr = 1'b0;
  endtask

  task automatic host_read(input logic [1:0] sel, output logic [15:0] v);
    @(negedge clk);
    host_rd = 1'b1; host_rsel = sel;
    @(negedge clk);
    host_rd = 1'b0;
    v = host_rdata;
  endtask

  task automatic send_pix(input int ch, input logic [7:0] r, g, b, input string tag);
    @(negedge clk);
    pix_valid = 1'b1; pix_ch = 2'(ch); pix_r = r; pix_g = g; pix_b = b;
    exp_q.push_back(expect_pix(ch, r, g, b));
    tag_q.push_back(tag);
    @(posedge clk); #1;
    pix_valid = 1'b0;
  endtask

  // Host data write and lookup on the same edge
  task automatic collide(input logic [7:0] d, input int ch, input logic [7:0] r, g, b);
    @(negedge clk);
    host_wr = 1'b1; host_sel = 2'd1; host_wdata = {8'h00, d};
    pix_valid = 1'b1; pix_ch = 2'(ch); pix_r = r; pix_g = g; pix_b = b;
    exp_q.push_back(expect_pix(ch, r, g, b));
    tag_q.push_back("R9 same-cycle lookup");
    mirror(2'd1, {8'h00, d});
    @(posedge clk); #1;
    host_wr = 1'b0; pix_valid = 1'b0;
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) begin
        n_checks++; n_fail++;
        $display("FAIL R7 unexpected out_valid actual=1 expected=0");
      end else begin
        check(tag_q.pop_front(), {out_r, out_g, out_b}, exp_q.pop_front());
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    rst = 1'b1; host_wr = 0; host_rd = 0; host_sel = 0; host_rsel = 0;
    host_wdata = 0; pix_valid = 0; pix_ch = 0; pix_r = 0; pix_g = 0; pix_b = 0;
    b_addr = 0; b_inc = 0; b_en = 3'b000;
    for (int i = 0; i < TOTAL; i++) model[i] = 8'h00;
    repeat (3) @(posedge clk); #1;
    rst = 1'b0;

    // R1: reset state
    @(negedge clk);
    check("R1 out_valid", 24'(out_valid), 24'd0);
    host_read(2'd0, v); check("R1 address", 24'(v), 24'h0000);
    host_read(2'd2, v); check("R1 enables", 24'(v), 24'h0000);

    // R8: everything disabled, and channel code 3
    send_pix(0, 8'h12, 8'h34, 8'h56, "R8 disabled ch0");
    send_pix(3, 8'hAB, 8'hCD, 8'hEF, "R8 channel 3");

    // R2: address loads and out-of-range values
    host_write(2'd0, 16'h8000 | 16'd100);
    host_read(2'd0, v); check("R2 address load", 24'(v), 24'h8064);
    host_write(2'd0, 16'd3000);
    host_read(2'd0, v); check("R2 out of range", 24'(v), 24'h0000);
    host_write(2'd0, 16'h7FFF);
    host_read(2'd0, v); check("R2 max field", 24'(v), 24'h0000);
    host_read(2'd1, v); check("R6 read select 1", 24'(v), 24'h0000);

    // R3/R5: full streamed load, address wraps back to 0
    host_write(2'd0, 16'h8000);
    for (int a = 0; a < TOTAL; a++) host_write(2'd1, {8'h00, pat(a)});
    host_read(2'd0, v); check("R5 wrap after sweep", 24'(v), 24'h8000);

    // R6: enables and inert select
    host_write(2'd2, 16'h0005);
    host_write(2'd3, 16'hFFFF);
    host_read(2'd2, v); check("R6 enables", 24'(v), 24'h0005);
    host_read(2'd0, v); check("R6 select 3 inert", 24'(v), 24'h8000);

    // R7/R8: mixed stream, back to back
    for (int i = 0; i < 24; i++) begin
      int ch = i % 4;
      send_pix(ch, 8'(i*11), 8'(255 - i*7), 8'(i*29),
               (ch == 0 || ch == 2) ? "R7 lookup" : "R8 bypass");
    end
    host_write(2'd2, 16'h0002);
    for (int i = 0; i < 9; i++)
      send_pix(i % 3, 8'(i*31 + 3), 8'(i*17), 8'(250 - i*13), "R8/R7 enables 010");

    // R3: layout, green table of channel 1 entry 0x40
    host_write(2'd2, 16'h0007);
    host_write(2'd0, 16'(768 + 256 + 'h40));
    host_write(2'd1, 16'h0099);
    send_pix(1, 8'h40, 8'h40, 8'h40, "R3 layout ch1 green");

    // R4: no auto-increment, last write wins
    host_write(2'd0, 16'(512 + 7));
    host_write(2'd1, 16'h0011);
    host_write(2'd1, 16'h0022);
    host_read(2'd0, v); check("R4 address held", 24'(v), 24'(512 + 7));
    send_pix(0, 8'h00, 8'h00, 8'h07, "R4 last write wins");

    // R5: wrap from the last entry
    host_write(2'd0, 16'h8000 | 16'd2303);
    host_write(2'd1, 16'h00A5);
    host_read(2'd0, v); check("R5 wrap to zero", 24'(v), 24'h8000);
    host_write(2'd1, 16'h003C);
    send_pix(2, 8'h10, 8'h20, 8'hFF, "R5 entry 2303");
    send_pix(0, 8'h00, 8'h01, 8'h02, "R5 entry 0");

    // R9: same-cycle write and lookup of one entry
    host_write(2'd0, 16'(2*768 + 10));
    collide(8'h5A, 2, 8'd10, 8'd3, 8'd4);
    send_pix(2, 8'd10, 8'd3, 8'd4, "R9 new value");

    repeat (3) @(negedge clk);
    check("R7 scoreboard drained", 24'(exp_q.size()), 24'd0);
    finish_run();
  end
endmodule